// File: doc/BRIEF.md
# Interrupt Flag and Wake Controller

This block holds the interrupt state of a small 8-bit processor core. Three sources feed it: an external pin whose active edge is chosen by a configuration input, a one-cycle overflow pulse from an 8-bit timer, and a group of upper port pins watched for any change of level. Each source owns a sticky flag and an enable bit. All of them sit in one 8-bit control register that software reads and writes as a whole. The block merges flags, enables and a global enable into a single interrupt request. The core answers that request with an accept strobe and later with a return strobe.

A second output, a one-cycle wake pulse, restarts a sleeping core when the external-pin flag rises. The core reports sleep entry with a strobe, and the block records at that moment whether the external-pin enable was set. Waking does not depend on the global enable. The core uses the global enable on its own to decide whether it branches to the vector or simply carries on.

Two state machines sit inside. The service machine has the states SVC_IDLE and SVC_ACTIVE. Its transition "take" (IDLE to ACTIVE, on accept while a request is up) clears the global enable, and its transition "retire" (ACTIVE to IDLE, on the return strobe) sets it again. The wake machine has the states WK_RUN, WK_SLEEP and WK_WAKE. Its transitions are "doze" (RUN to SLEEP on the sleep strobe, which also captures the arm bit), "rouse" (SLEEP to WAKE when the device is armed and the external flag is set) and "resume" (WAKE to RUN, always, after one cycle).

Top module: `irq_flag_ctrl`

## Requirements
- R1: After reset, ctl_rdata reads 8'h00, and irq_req and wake are 0.
- R2: With edge_rise_sel=1, a low-to-high change on ext_pin sets control bit 1; with edge_rise_sel=0, a high-to-low change sets it. The opposite edge has no effect. The bit is visible three rising clock edges after the pin changes, counting from the first edge that samples the new level.
- R3: Flags (bit 0 port change, bit 1 external pin, bit 2 timer) are never cleared by hardware. A write through ctl_wr_en loads all writable bits from ctl_wdata, so writing 0 to a flag clears it and writing 1 sets it.
- R4: If control bit 4 is set when sleep_enter pulses, a later set of bit 1 produces wake=1 for exactly one cycle, on the edge after the flag is set. If bit 4 was clear at sleep entry, no wake pulse follows, even if bit 4 is written to 1 during sleep. The wake pulse does not change the global enable.
- R5: A tmr_ovf pulse sets control bit 2 at the next clock edge.
- R6: irq_req equals bit 7 ANDed with the OR of (bit0 AND bit3), (bit1 AND bit4) and (bit2 AND bit5).
- R7: Bit 0 is set on every cycle in which the synchronized port_hi differs from a stored reference. A port_rd strobe loads the reference with the synchronized value. While a mismatch persists, a software clear of bit 0 does not stick.
- R8: irq_accept while irq_req=1 and no service is active clears bit 7. irq_return during an active service sets bit 7 again. irq_return outside a service has no effect.
- R9: When a hardware set event and a software write of 0 hit the same flag in the same cycle, the flag ends up set.
- R10: Bit 6 always reads 0. Writes to bit 6 are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ext_pin | input | 1 | External interrupt pin, asynchronous |
| edge_rise_sel | input | 1 | 1 selects the rising edge, 0 selects the falling edge |
| port_hi | input | PORT_W | Watched port pins, asynchronous |
| port_rd | input | 1 | Software port read strobe; reloads the change reference |
| tmr_ovf | input | 1 | Timer roll-over pulse |
| ctl_wr_en | input | 1 | Control register write strobe |
| ctl_wdata | input | 8 | Control register write data |
| sleep_enter | input | 1 | Core enters sleep |
| irq_accept | input | 1 | Core takes the interrupt |
| irq_return | input | 1 | Core returns from the interrupt |
| ctl_rdata | output | 8 | Control register read value |
| irq_req | output | 1 | Interrupt request to the core |
| wake | output | 1 | One-cycle wake pulse |

## Verification
The bench builds the block with its default parameters: four watched port pins and a two-stage synchronizer. This puts the full three-edge latency from pin to flag inside every cycle-by-cycle comparison. At that depth the bench can also land a port-read strobe on the same edge as a live mismatch, and a software clear on the same edge as a timer pulse. Both wake paths, armed and unarmed, are reached by entering sleep with and without the external enable, including a late enable written during sleep.

// File: rtl/irq_pkg.sv
package irq_pkg;
    localparam int CTL_W     = 8;
    localparam int SRC_N     = 3;
    // source index: 0 port change, 1 external pin, 2 timer
    localparam int SRC_PORT  = 0;
    localparam int SRC_EXT   = 1;
    localparam int SRC_TMR   = 2;
    localparam int FLAG_LSB  = 0;
    localparam int EN_LSB    = 3;
    localparam int GIE_BIT   = 7;
    localparam int RSVD_BIT  = 6;

    typedef enum logic {
        SVC_IDLE,
        SVC_ACTIVE
    } svc_state_t;

    typedef enum logic [1:0] {
        WK_RUN,
        WK_SLEEP,
        WK_WAKE
    } wk_state_t;
endpackage

// File: rtl/irq_sync.sv
module irq_sync #(
    parameter int W      = 5,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    logic [W-1:0] stg [STAGES];

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) stg[0] <= '0;
                    else        stg[0] <= din;
                end
            end else begin : g_next
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) stg[s] <= '0;
                    else        stg[s] <= stg[s-1];
                end
            end
        end
    endgenerate

    assign dout = stg[STAGES-1];
endmodule

// File: rtl/irq_detect.sv
module irq_detect #(
    parameter int PORT_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ext_s,
    input  logic              rise_sel,
    input  logic [PORT_W-1:0] port_s,
    input  logic              port_rd,
    output logic              ext_evt,
    output logic              port_evt
);
    logic              ext_prev;
    logic [PORT_W-1:0] port_ref;
    logic              rose_now;
    logic              fell_now;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ext_prev <= 1'b0;
            port_ref <= '0;
        end else begin
            ext_prev <= ext_s;
            if (port_rd) port_ref <= port_s;
        end
    end

    always_comb begin
        rose_now = ext_s & ~ext_prev;
        fell_now = ~ext_s & ext_prev;
        ext_evt  = rise_sel ? rose_now : fell_now;
        port_evt = |(port_s ^ port_ref);
    end

    // R2
    edge_polarity_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ext_evt |-> (ext_s == rise_sel));
endmodule

// File: rtl/irq_svc_fsm.sv
module irq_svc_fsm
    import irq_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic irq_accept,
    input  logic irq_req,
    input  logic irq_return,
    output logic gie_clr,
    output logic gie_set,
    output logic in_service
);
    svc_state_t state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= SVC_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SVC_IDLE:   if (irq_accept && irq_req) state_d = SVC_ACTIVE;
            SVC_ACTIVE: if (irq_return)            state_d = SVC_IDLE;
            default:                               state_d = SVC_IDLE;
        endcase
    end

    always_comb begin
        gie_clr    = 1'b0;
        gie_set    = 1'b0;
        in_service = 1'b0;
        unique case (state_q)
            SVC_IDLE:   gie_clr = irq_accept && irq_req;
            SVC_ACTIVE: begin
                in_service = 1'b1;
                gie_set    = irq_return;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/irq_wake_fsm.sv
module irq_wake_fsm
    import irq_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic sleep_enter,
    input  logic ext_en,
    input  logic ext_flag,
    output logic wake
);
    wk_state_t state_q, state_d;
    logic      armed_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= WK_RUN;
            armed_q <= 1'b0;
        end else begin
            state_q <= state_d;
            if (state_q == WK_RUN && sleep_enter) armed_q <= ext_en;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            WK_RUN:   if (sleep_enter)          state_d = WK_SLEEP;
            WK_SLEEP: if (armed_q && ext_flag)  state_d = WK_WAKE;
            WK_WAKE:                            state_d = WK_RUN;
            default:                            state_d = WK_RUN;
        endcase
    end

    always_comb begin
        wake = 1'b0;
        unique case (state_q)
            WK_WAKE: wake = 1'b1;
            default: wake = 1'b0;
        endcase
    end

    // R4
    wake_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wake |=> !wake);
endmodule

// File: rtl/irq_flag_ctrl.sv
module irq_flag_ctrl
    import irq_pkg::*;
#(
    parameter int PORT_W      = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ext_pin,
    input  logic              edge_rise_sel,
    input  logic [PORT_W-1:0] port_hi,
    input  logic              port_rd,
    input  logic              tmr_ovf,
    input  logic              ctl_wr_en,
    input  logic [CTL_W-1:0]  ctl_wdata,
    input  logic              sleep_enter,
    input  logic              irq_accept,
    input  logic              irq_return,
    output logic [CTL_W-1:0]  ctl_rdata,
    output logic              irq_req,
    output logic              wake
);
    localparam int SYNC_W = PORT_W + 1;

    logic [SYNC_W-1:0] sync_in, sync_out;
    logic              ext_evt, port_evt;
    logic [SRC_N-1:0]  set_evt;
    logic [SRC_N-1:0]  flag_q, en_q;
    logic              gie_q;
    logic              gie_clr, gie_set, in_service;
    logic              unused_rsvd;

    assign sync_in     = {port_hi, ext_pin};
    assign unused_rsvd = ctl_wdata[RSVD_BIT];

    irq_sync #(.W(SYNC_W), .STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .din(sync_in), .dout(sync_out)
    );

    irq_detect #(.PORT_W(PORT_W)) u_detect (
        .clk(clk), .rst_n(rst_n),
        .ext_s(sync_out[0]), .rise_sel(edge_rise_sel),
        .port_s(sync_out[SYNC_W-1:1]), .port_rd(port_rd),
        .ext_evt(ext_evt), .port_evt(port_evt)
    );

    always_comb begin
        set_evt           = '0;
        set_evt[SRC_PORT] = port_evt;
        set_evt[SRC_EXT]  = ext_evt;
        set_evt[SRC_TMR]  = tmr_ovf;
    end

    generate
        for (genvar i = 0; i < SRC_N; i++) begin : g_src
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    flag_q[i] <= 1'b0;
                    en_q[i]   <= 1'b0;
                end else begin
                    // hardware set wins over a software clear
                    flag_q[i] <= set_evt[i] |
                                 (ctl_wr_en ? ctl_wdata[FLAG_LSB+i] : flag_q[i]);
                    if (ctl_wr_en) en_q[i] <= ctl_wdata[EN_LSB+i];
                end
            end
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)         gie_q <= 1'b0;
        else if (gie_clr)   gie_q <= 1'b0;
        else if (gie_set)   gie_q <= 1'b1;
        else if (ctl_wr_en) gie_q <= ctl_wdata[GIE_BIT];
    end

    irq_svc_fsm u_svc (
        .clk(clk), .rst_n(rst_n),
        .irq_accept(irq_accept), .irq_req(irq_req), .irq_return(irq_return),
        .gie_clr(gie_clr), .gie_set(gie_set), .in_service(in_service)
    );

    irq_wake_fsm u_wake (
        .clk(clk), .rst_n(rst_n),
        .sleep_enter(sleep_enter), .ext_en(en_q[SRC_EXT]),
        .ext_flag(flag_q[SRC_EXT]), .wake(wake)
    );

    always_comb begin
        ctl_rdata                           = '0;
        ctl_rdata[FLAG_LSB +: SRC_N]        = flag_q;
        ctl_rdata[EN_LSB +: SRC_N]          = en_q;
        ctl_rdata[GIE_BIT]                  = gie_q;
        irq_req = gie_q & |(flag_q & en_q);
    end

    // R5 R9
    tmr_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tmr_ovf |=> ctl_rdata[FLAG_LSB+SRC_TMR]);

    // R3
    ext_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(flag_q[SRC_EXT]) |-> $past(ctl_wr_en));

    // R6
    req_needs_gie_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_req |-> ctl_rdata[GIE_BIT]);

    // R8
    accept_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_accept && irq_req && !in_service) |=> !ctl_rdata[GIE_BIT]);
endmodule

// File: tb/irq_flag_ctrl_bench.sv
module irq_flag_ctrl_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ext_pin = 1'b0, edge_rise_sel = 1'b0;
    logic [3:0] port_hi = 4'h0;
    logic       port_rd = 1'b0, tmr_ovf = 1'b0, ctl_wr_en = 1'b0;
    logic [7:0] ctl_wdata = 8'h00;
    logic       sleep_enter = 1'b0, irq_accept = 1'b0, irq_return = 1'b0;
    logic [7:0] ctl_rdata;
    logic       irq_req, wake;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    irq_flag_ctrl u_irq_flag_ctrl (
        .clk(clk), .rst_n(rst_n), .ext_pin(ext_pin), .edge_rise_sel(edge_rise_sel),
        .port_hi(port_hi), .port_rd(port_rd), .tmr_ovf(tmr_ovf),
        .ctl_wr_en(ctl_wr_en), .ctl_wdata(ctl_wdata), .sleep_enter(sleep_enter),
        .irq_accept(irq_accept), .irq_return(irq_return),
        .ctl_rdata(ctl_rdata), .irq_req(irq_req), .wake(wake)
    );

    // behavioural reference: delay queues for the pins, plain bits for state
    bit   ext_q[$];
    bit [3:0] port_q[$];
    bit   m_prev, m_valid;
    bit [3:0] m_ref;
    bit [2:0] m_flag, m_en;
    bit   m_gie, m_busy, m_armed;
    int   m_wk;      // 0 run, 1 sleep, 2 wake

    function automatic bit m_req();
        return m_gie && ((m_flag & m_en) != 3'b000);
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            ext_q = '{0, 0};
            port_q = '{4'h0, 4'h0};
            m_prev = 0; m_ref = 0; m_flag = 0; m_en = 0;
            m_gie = 0; m_busy = 0; m_armed = 0; m_wk = 0; m_valid = 1;
        end else begin
            bit e_now, e_evt, p_evt, req;
            bit [3:0] p_now;
            bit [2:0] ev;
            e_now = ext_q[1];
            p_now = port_q[1];
            e_evt = edge_rise_sel ? (e_now && !m_prev) : (!e_now && m_prev);
            p_evt = (p_now != m_ref);
            req = m_req();
            ev = {tmr_ovf, e_evt, p_evt};
            if (m_wk == 0) begin
                if (sleep_enter) begin m_wk = 1; m_armed = m_en[1]; end
            end else if (m_wk == 1) begin
                if (m_armed && m_flag[1]) m_wk = 2;
            end else m_wk = 0;
            if (!m_busy && irq_accept && req) begin m_busy = 1; m_gie = 0; end
            else if (m_busy && irq_return) begin m_busy = 0; m_gie = 1; end
            else if (ctl_wr_en) m_gie = ctl_wdata[7];
            m_flag = ev | (ctl_wr_en ? ctl_wdata[2:0] : m_flag);
            if (ctl_wr_en) m_en = ctl_wdata[5:3];
            if (port_rd) m_ref = p_now;
            m_prev = e_now;
            void'(ext_q.pop_back());  ext_q.push_front(ext_pin);
            void'(port_q.pop_back()); port_q.push_front(port_hi);
        end
    end

    task automatic cmp(bit act, bit exp, string req, string what);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (rst_n && m_valid) begin
            cmp(ctl_rdata[0], m_flag[0], "R7", "port flag");
            cmp(ctl_rdata[1], m_flag[1], "R2", "ext flag");
            cmp(ctl_rdata[2], m_flag[2], "R5", "tmr flag");
            cmp(ctl_rdata[7], m_gie,     "R8", "global enable");
            cmp(ctl_rdata[6], 1'b0,      "R10", "reserved bit");
            cmp(irq_req,      m_req(),   "R6", "irq_req");
            cmp(wake,         m_wk == 2, "R4", "wake");
        end
    end

    task automatic tick(int n);
        repeat (n) @(posedge clk);
        #2;
    endtask

    task automatic chk8(logic [7:0] act, logic [7:0] exp, string req);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic wr(logic [7:0] v);
        ctl_wr_en = 1; ctl_wdata = v;
        tick(1);
        ctl_wr_en = 0;
    endtask

    task automatic do_reset();
        rst_n = 0;
        tick(3);
        rst_n = 1;
        tick(1);
    endtask

    initial begin
        #1_000_000;
        errors++;
        $display("FAIL R1 watchdog actual=running expected=finished");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        int pulses;
        tick(1);
        do_reset();
        // R1 reset state
        chk8(ctl_rdata, 8'h00, "R1 rdata");
        chk8({7'd0, irq_req}, 8'h00, "R1 irq_req");
        chk8({7'd0, wake}, 8'h00, "R1 wake");

        // R2 rising edge, three-edge latency
        edge_rise_sel = 1; ext_pin = 1;
        tick(2); chk8({7'd0, ctl_rdata[1]}, 8'h00, "R2 before latency");
        tick(1); chk8({7'd0, ctl_rdata[1]}, 8'h01, "R2 rising sets");
        wr(8'h00); chk8({7'd0, ctl_rdata[1]}, 8'h00, "R3 write clears");
        ext_pin = 0; tick(4);
        chk8({7'd0, ctl_rdata[1]}, 8'h00, "R2 falling ignored in rising mode");
        // R2 falling edge mode
        edge_rise_sel = 0; ext_pin = 1; tick(4);
        chk8({7'd0, ctl_rdata[1]}, 8'h00, "R2 rising ignored in falling mode");
        ext_pin = 0; tick(3);
        chk8({7'd0, ctl_rdata[1]}, 8'h01, "R2 falling sets");
        tick(5); chk8({7'd0, ctl_rdata[1]}, 8'h01, "R3 flag sticky");
        wr(8'h00); chk8(ctl_rdata, 8'h00, "R3 cleared");
        wr(8'h07); chk8(ctl_rdata, 8'h07, "R3 software sets flags");
        wr(8'h00);

        // R5 timer and R9 set-wins
        tmr_ovf = 1; tick(1); tmr_ovf = 0;
        chk8({7'd0, ctl_rdata[2]}, 8'h01, "R5 timer sets");
        tmr_ovf = 1; wr(8'h00); tmr_ovf = 0;
        chk8({7'd0, ctl_rdata[2]}, 8'h01, "R9 set beats clear");
        wr(8'h00); chk8(ctl_rdata, 8'h00, "R9 later clear");

        // R7 port change and reference reload
        port_hi = 4'b0001; tick(3);
        chk8({7'd0, ctl_rdata[0]}, 8'h01, "R7 change sets");
        wr(8'h00); chk8({7'd0, ctl_rdata[0]}, 8'h01, "R7 mismatch persists");
        port_rd = 1; tick(1); port_rd = 0;
        wr(8'h00); chk8({7'd0, ctl_rdata[0]}, 8'h00, "R7 clear after read");
        tick(3); chk8({7'd0, ctl_rdata[0]}, 8'h00, "R7 stays clear");
        port_hi = 4'b1001; tick(3);
        chk8({7'd0, ctl_rdata[0]}, 8'h01, "R7 upper pin change");
        port_rd = 1; tick(1); port_rd = 0; wr(8'h00);

        // R6 request combinations
        wr(8'h24); chk8({7'd0, irq_req}, 8'h00, "R6 no global");
        wr(8'h94); chk8({7'd0, irq_req}, 8'h00, "R6 enable mismatch");
        wr(8'hA4); chk8({7'd0, irq_req}, 8'h01, "R6 request");
        wr(8'h89); chk8({7'd0, irq_req}, 8'h01, "R6 port pair");

        // R8 accept / return
        wr(8'hA4);
        irq_accept = 1; tick(1); irq_accept = 0;
        chk8({7'd0, ctl_rdata[7]}, 8'h00, "R8 accept clears");
        chk8({7'd0, irq_req}, 8'h00, "R8 request dropped");
        irq_return = 1; tick(1); irq_return = 0;
        chk8({7'd0, ctl_rdata[7]}, 8'h01, "R8 return sets");
        wr(8'h24);
        irq_return = 1; tick(1); irq_return = 0;
        chk8({7'd0, ctl_rdata[7]}, 8'h00, "R8 stray return ignored");

        // R10 reserved bit
        wr(8'hFF); chk8(ctl_rdata, 8'hBF, "R10 bit6 reads 0");
        wr(8'h00);

        // R4 armed wake, global enable clear
        wr(8'h10);
        sleep_enter = 1; tick(1); sleep_enter = 0;
        edge_rise_sel = 1; ext_pin = 1;
        pulses = 0;
        for (int i = 0; i < 10; i++) begin
            tick(1);
            if (wake) pulses++;
        end
        chk8(pulses[7:0], 8'd1, "R4 one wake pulse");
        chk8({7'd0, ctl_rdata[7]}, 8'h00, "R4 global enable untouched");

        // R4 unarmed sleep, enable written late
        do_reset();
        ext_pin = 0; tick(3);
        sleep_enter = 1; tick(1); sleep_enter = 0;
        wr(8'h10);
        ext_pin = 1;
        pulses = 0;
        for (int i = 0; i < 10; i++) begin
            tick(1);
            if (wake) pulses++;
        end
        chk8(pulses[7:0], 8'd0, "R4 no wake when unarmed");
        chk8({7'd0, ctl_rdata[1]}, 8'h01, "R4 flag still set");

        tick(2);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule